// File: doc/BRIEF.md
# Word-Serial Radix-4 Montgomery Multiplier

The block computes a Montgomery product of two operands modulo an odd modulus. One processing step walks the partial sum, the multiplicand and the modulus one W-bit word at a time. Each outer pass consumes one signed radix-4 digit of the multiplier and adds a signed multiple of the multiplicand. It then adds the signed multiple of the modulus that clears the two lowest sum bits. The whole sum is then shifted right by two bits, and each word takes the low bits of the word above it.

The host drives the three operands in parallel and pulses `start`. The block is busy for a fixed number of cycles. It then presents the reduced product on `res` together with a one-cycle `done`. The running sum carries one guard word above the operand words, which holds sign and carry growth. A final single-cycle correction brings the signed result into the range [0, M).

Top module: `mont_mul_r4`

## Requirements
- R1: While `rst` is high and after it falls, `busy`, `done` and `res` are all zero until the first operation finishes.
- R2: For an odd modulus M with 3 <= M < 2^(N_BITS-1) and operands A, B < M, `res` equals A·B·2^(-2D) mod M, with D = ceil(N_BITS/2). The value lies in [0, M).
- R3: Multiplier digit j is taken from bits {a[2j+1], a[2j], a[2j-1]}, with a[-1] = 0, starting at the least significant digit. The digit maps 000 and 111 to 0, 001 and 010 to +1, 011 to +2, 100 to -2, and 101 and 110 to -1.
- R4: The modulus multiple is chosen in word step 0 from t = (s[1:0] · (-M mod 4)) mod 4. Here s is sum word 0 after the multiplicand multiple has been added. t maps 0 to 0, 1 to +1, 2 to +2 and 3 to -1. The low two bits of the new sum word 0 are then zero.
- R5: Multiples (doubling and two's-complement negation) and both carry chains propagate across word boundaries. They give exact results for operands at the top of their range.
- R6: After the last digit, a signed sum below zero is increased by M, and a sum of at least M is decreased by M, once.
- R7: `done` rises D·(E+1)+1 clock edges after the edge that captures `start`, where E = ceil(N_BITS/W).
- R8: `done` is high for exactly one cycle, and `res` holds its value until the next `done`.
- R9: `start` while `busy` is high is ignored: the running result, its latency and the later idle state are unaffected.
- R10: A `start` held in the cycle where `done` is high is accepted and begins a new operation at once.
- R11: Operands are sampled only on the capture edge; later changes to `a_in`, `b_in` or `m_in` do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| a_in | input | N_BITS | Multiplier operand A |
| b_in | input | N_BITS | Multiplicand operand B |
| m_in | input | N_BITS | Odd modulus M |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| res | output | N_BITS | Reduced Montgomery product |

## Verification
Two functions can fall in the same cycle: the end of one operation, with its result register and `done` pulse, and the acceptance of the next `start`. A further overlap occurs when a `start` arrives mid-run. The bench raises `start` in the exact cycle where it first observes `done`. It then judges that the old result stays on `res` while the second product is computed, and that the second product arrives with the nominal latency. A mid-run `start` with different operands must leave the first result and its timing unchanged.

// File: rtl/mont_pkg.sv
package mont_pkg;

  typedef struct packed {
    logic       neg;
    logic [1:0] mag;
  } mult_sel_t;

  function automatic mult_sel_t booth_sel(input logic [2:0] t);
    mult_sel_t r;
    r.neg = 1'b0;
    r.mag = 2'd0;
    case (t)
      3'b001, 3'b010: r.mag = 2'd1;
      3'b011:         r.mag = 2'd2;
      3'b100: begin r.neg = 1'b1; r.mag = 2'd2; end
      3'b101, 3'b110: begin r.neg = 1'b1; r.mag = 2'd1; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic mult_sel_t mod_sel(input logic [1:0] t);
    mult_sel_t r;
    r.neg = 1'b0;
    r.mag = 2'd0;
    case (t)
      2'd1: r.mag = 2'd1;
      2'd2: r.mag = 2'd2;
      2'd3: begin r.neg = 1'b1; r.mag = 2'd1; end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mont_word_mult.sv
module mont_word_mult
  import mont_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] word,
  input  logic         prev_msb,
  input  mult_sel_t    sel,
  output logic [W-1:0] mult
);
  logic [W-1:0] mag_w;

  always_comb begin
    case (sel.mag)
      2'd1:    mag_w = word;
      2'd2:    mag_w = {word[W-2:0], prev_msb};
      default: mag_w = '0;
    endcase
    mult = sel.neg ? ~mag_w : mag_w;
  end
endmodule

// File: rtl/mont_word_pe.sv
module mont_word_pe
  import mont_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] s_w,
  input  logic [W-1:0] b_w,
  input  logic [W-1:0] m_w,
  input  logic         pb_msb,
  input  logic         pm_msb,
  input  logic         first,
  input  logic         ca,
  input  logic         cb,
  input  mult_sel_t    qa,
  input  mult_sel_t    qm_hold,
  input  logic [1:0]   minv_neg,
  output logic [W-1:0] word_out,
  output logic         ca_next,
  output logic         cb_next,
  output mult_sel_t    qm_now
);
  logic [W-1:0] pa_w, pm_w;
  logic [W:0]   sum_a, sum_b;
  logic         cin_a, cin_b;
  logic [1:0]   tsel;

  mont_word_mult #(.W(W)) u_mul_b (.word(b_w), .prev_msb(pb_msb), .sel(qa),     .mult(pa_w));
  mont_word_mult #(.W(W)) u_mul_m (.word(m_w), .prev_msb(pm_msb), .sel(qm_now), .mult(pm_w));

  always_comb begin
    cin_a   = first ? qa.neg : ca;
    sum_a   = {1'b0, s_w} + {1'b0, pa_w} + {{W{1'b0}}, cin_a};
    tsel    = 2'(sum_a[1:0] * minv_neg);
    qm_now  = first ? mod_sel(tsel) : qm_hold;
    cin_b   = first ? qm_now.neg : cb;
    sum_b   = {1'b0, sum_a[W-1:0]} + {1'b0, pm_w} + {{W{1'b0}}, cin_b};
    word_out = sum_b[W-1:0];
    ca_next  = sum_a[W];
    cb_next  = sum_b[W];
  end
endmodule

// File: rtl/mont_final_fix.sv
module mont_final_fix #(
  parameter int N_BITS = 16,
  parameter int SW     = 20
) (
  input  logic [SW-1:0]     s,
  input  logic [N_BITS-1:0] m,
  output logic [N_BITS-1:0] r
);
  logic signed [SW-1:0] sv, mv, t;

  always_comb begin
    sv = s;
    mv = {{(SW-N_BITS){1'b0}}, m};
    if (sv[SW-1])      t = sv + mv;
    else if (sv >= mv) t = sv - mv;
    else               t = sv;
    r = t[N_BITS-1:0];
  end
endmodule

// File: rtl/mont_mul_r4.sv
module mont_mul_r4
  import mont_pkg::*;
#(
  parameter int N_BITS = 16,
  parameter int W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [N_BITS-1:0] a_in,
  input  logic [N_BITS-1:0] b_in,
  input  logic [N_BITS-1:0] m_in,
  output logic              busy,
  output logic              done,
  output logic [N_BITS-1:0] res
);
  localparam int E    = (N_BITS + W - 1) / W;
  localparam int SW   = (E + 1) * W;
  localparam int D    = (N_BITS + 1) / 2;
  localparam int AW   = 2 * D + 1;
  localparam int WIDX = $clog2(E + 1);
  localparam int ITW  = (D > 1) ? $clog2(D) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} state_t;

  state_t          state;
  logic [SW-1:0]   b_r, m_r, s_r;
  logic [AW-1:0]   a_r;
  logic [WIDX-1:0] wi;
  logic [ITW-1:0]  it;
  logic            ca, cb, pb_msb, pm_msb;
  mult_sel_t       qm_r;
  logic [W-1:0]    hold;

  logic            in_run, step0;
  mult_sel_t       qa, qm_now;
  logic [W-1:0]    s_w, b_w, m_w, pe_word;
  logic            ca_n, cb_n;
  logic [1:0]      minv_neg;
  logic [N_BITS-1:0] fix_out;

  assign in_run   = (state == ST_RUN);
  assign step0    = (wi == '0);
  assign qa       = booth_sel(a_r[2:0]);
  assign s_w      = s_r[int'(wi)*W +: W];
  assign b_w      = b_r[int'(wi)*W +: W];
  assign m_w      = m_r[int'(wi)*W +: W];
  assign minv_neg = 2'd0 - m_r[1:0];

  mont_word_pe #(.W(W)) u_pe (
    .s_w(s_w), .b_w(b_w), .m_w(m_w), .pb_msb(pb_msb), .pm_msb(pm_msb),
    .first(step0), .ca(ca), .cb(cb), .qa(qa), .qm_hold(qm_r),
    .minv_neg(minv_neg), .word_out(pe_word), .ca_next(ca_n),
    .cb_next(cb_n), .qm_now(qm_now)
  );

  mont_final_fix #(.N_BITS(N_BITS), .SW(SW)) u_fix (
    .s(s_r), .m(m_r[N_BITS-1:0]), .r(fix_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      b_r    <= '0;
      m_r    <= '0;
      s_r    <= '0;
      a_r    <= '0;
      wi     <= '0;
      it     <= '0;
      ca     <= 1'b0;
      cb     <= 1'b0;
      pb_msb <= 1'b0;
      pm_msb <= 1'b0;
      qm_r   <= '0;
      hold   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      res    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          done <= 1'b0;
          if (start) begin
            b_r    <= SW'(b_in);
            m_r    <= SW'(m_in);
            a_r    <= AW'({a_in, 1'b0});
            s_r    <= '0;
            wi     <= '0;
            it     <= '0;
            pb_msb <= 1'b0;
            pm_msb <= 1'b0;
            busy   <= 1'b1;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          ca     <= ca_n;
          cb     <= cb_n;
          pb_msb <= b_w[W-1];
          pm_msb <= m_w[W-1];
          hold   <= pe_word;
          if (step0) qm_r <= qm_now;
          if (!step0) s_r[(int'(wi)-1)*W +: W] <= {pe_word[1:0], hold[W-1:2]};
          if (wi == WIDX'(E)) begin
            s_r[E*W +: W] <= {{2{pe_word[W-1]}}, pe_word[W-1:2]};
            wi     <= '0;
            pb_msb <= 1'b0;
            pm_msb <= 1'b0;
            a_r    <= a_r >> 2;
            if (it == ITW'(D - 1)) state <= ST_FIX;
            else                   it <= it + 1'b1;
          end else begin
            wi <= wi + 1'b1;
          end
        end
        ST_FIX: begin
          res   <= fix_out;
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mont_mul_r4_chk.sv
module mont_mul_r4_chk #(
  parameter int N_BITS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [N_BITS-1:0] res,
  input logic [N_BITS-1:0] mod_q,
  input logic              in_run,
  input logic              step0,
  input logic [1:0]        pe_low
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_RES_BELOW_MOD: assert property (@(posedge clk) disable iff (rst) done |-> (res < mod_q)); // R2
  AST_QM_CLEARS_LOW: assert property (@(posedge clk) disable iff (rst) (in_run && step0) |-> (pe_low == 2'b00)); // R4
  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (rst) (busy && start) |=> $stable(mod_q)); // R9
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> $past(busy)); // R7
endmodule

bind mont_mul_r4 mont_mul_r4_chk #(.N_BITS(N_BITS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .res(res),
  .mod_q(m_r[N_BITS-1:0]), .in_run(in_run), .step0(step0), .pe_low(pe_word[1:0])
);

// File: tb/tb_mont_mul_r4.sv
`timescale 1ns/1ps
module tb_mont_mul_r4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st0 = 1'b0, st1 = 1'b0;
  logic [31:0] a_d = '0, b_d = '0, m_d = '0;
  logic busy0, done0, busy1, done1;
  logic [15:0] r0;
  logic [31:0] r1;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  mont_mul_r4 #(.N_BITS(16), .W(4)) dut (
    .clk(clk), .rst(rst), .start(st0), .a_in(a_d[15:0]), .b_in(b_d[15:0]),
    .m_in(m_d[15:0]), .busy(busy0), .done(done0), .res(r0));

  mont_mul_r4 #(.N_BITS(32), .W(8)) dut_w (
    .clk(clk), .rst(rst), .start(st1), .a_in(a_d), .b_in(b_d),
    .m_in(m_d), .busy(busy1), .done(done1), .res(r1));

  function automatic int nbits(input int sel); return sel ? 32 : 16; endfunction
  function automatic int exp_lat(input int sel);
    return sel ? (16 * 5 + 1) : (8 * 5 + 1);
  endfunction

  function automatic logic [31:0] ref_mm(input int nb, input logic [31:0] a, b, m);
    logic [63:0] x;
    x = ({32'b0, a} * {32'b0, b}) % {32'b0, m};
    for (int k = 0; k < 2 * ((nb + 1) / 2); k++)
      x = x[0] ? ((x + {32'b0, m}) >> 1) : (x >> 1);
    return x[31:0];
  endfunction

  function automatic logic dn(input int sel); return sel ? done1 : done0; endfunction
  function automatic logic bz(input int sel); return sel ? busy1 : busy0; endfunction
  function automatic logic [31:0] rr(input int sel); return sel ? r1 : {16'b0, r0}; endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic pulse_start(input int sel, input logic [31:0] a, b, m);
    @(negedge clk);
    a_d = a; b_d = b; m_d = m;
    if (sel) st1 = 1'b1; else st0 = 1'b1;
    @(negedge clk);
    st0 = 1'b0; st1 = 1'b0;
  endtask

  task automatic wait_done(input int sel, inout int lat);
    while (!dn(sel) && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_mul(input int sel, input logic [31:0] a, b, m, input string req);
    int lat = 0;
    logic [31:0] e;
    e = ref_mm(nbits(sel), a, b, m);
    pulse_start(sel, a, b, m);
    wait_done(sel, lat);
    check(rr(sel) == e, req, rr(sel), e);
    check(lat == exp_lat(sel), "R7 latency", lat, exp_lat(sel));
    @(negedge clk);
    check(!dn(sel) && rr(sel) == e, "R8 done single, res held", {31'b0, dn(sel)}, 0);
  endtask

  task automatic t_reset();
    check(!busy0 && !done0 && r0 == 0, "R1 reset narrow", {16'b0, r0}, 0);
    check(!busy1 && !done1 && r1 == 0, "R1 reset wide", r1, 0);
  endtask

  task automatic t_directed();
    t_mul(0, 0, 16'h1234, 16'h6AB3, "R6 zero multiplier");
    t_mul(0, 1, 1, 16'h6AB3, "R2 unit operands");
    t_mul(0, 16'h5554, 16'h2AAA, 16'h7FFF, "R3 alternating digits");
    t_mul(0, 16'h2AAA, 16'h5555, 16'h7FFD, "R3 alternating digits shifted");
    t_mul(0, 16'h7FFE, 16'h7FFE, 16'h7FFF, "R5 top of range");
    t_mul(0, 16'h0F00, 16'h0EFF, 16'h0F01, "R4 modulus 1 mod 4");
    t_mul(0, 16'h6AB2, 16'h6AB1, 16'h6AB3, "R4 modulus 3 mod 4");
    t_mul(1, 32'h7FFFFFFE, 32'h7FFFFFFE, 32'h7FFFFFFF, "R5 wide top of range");
    t_mul(1, 32'h55555554, 32'h12345678, 32'h6AB3C5D7, "R3 wide alternating");
  endtask

  task automatic t_random(input int sel, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      logic [31:0] mask, m, a, b;
      mask = sel ? 32'h7FFFFFFF : 32'h00007FFF;
      m = ($urandom & mask) | 32'h1;
      if (m < 3) m = 3;
      a = $urandom % m;
      b = $urandom % m;
      t_mul(sel, a, b, m, "R2 R6 random operands");
    end
  endtask

  task automatic t_busy_start(input int sel);
    int lat = 0;
    logic [31:0] e, held;
    e = ref_mm(nbits(sel), 32'h1357, 32'h2468, 32'h7001);
    pulse_start(sel, 32'h1357, 32'h2468, 32'h7001);
    a_d = 32'h0111; b_d = 32'h0222; m_d = 32'h0333;
    repeat (5) begin @(negedge clk); lat++; end
    if (sel) st1 = 1'b1; else st0 = 1'b1;
    @(negedge clk); lat++;
    st0 = 1'b0; st1 = 1'b0;
    a_d = 32'h0ABC; b_d = 32'h0DEF; m_d = 32'h0F11;
    wait_done(sel, lat);
    check(rr(sel) == e, "R9 R11 busy start ignored", rr(sel), e);
    check(lat == exp_lat(sel), "R9 latency unchanged", lat, exp_lat(sel));
    held = rr(sel);
    repeat (exp_lat(sel) + 4) @(negedge clk);
    check(!bz(sel) && !dn(sel) && rr(sel) == held, "R9 no queued start", rr(sel), held);
  endtask

  task automatic t_back2back(input int sel);
    int lat = 0;
    logic [31:0] e1, e2;
    e1 = ref_mm(nbits(sel), 32'h0777, 32'h0345, 32'h7F01);
    e2 = ref_mm(nbits(sel), 32'h6000, 32'h5FFF, 32'h7F03);
    pulse_start(sel, 32'h0777, 32'h0345, 32'h7F01);
    wait_done(sel, lat);
    check(rr(sel) == e1, "R2 first of pair", rr(sel), e1);
    a_d = 32'h6000; b_d = 32'h5FFF; m_d = 32'h7F03;
    if (sel) st1 = 1'b1; else st0 = 1'b1;
    @(negedge clk);
    st0 = 1'b0; st1 = 1'b0;
    check(bz(sel) && rr(sel) == e1, "R10 accepted in done cycle, R8 old res held", rr(sel), e1);
    lat = 0;
    wait_done(sel, lat);
    check(rr(sel) == e2, "R10 second of pair", rr(sel), e2);
    check(lat == exp_lat(sel), "R10 latency", lat, exp_lat(sel));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_directed();
    t_random(0, 30);
    t_random(1, 30);
    t_busy_start(0);
    t_busy_start(1);
    t_back2back(0);
    t_back2back(1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R7 watchdog act=%0d exp=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule